// File: doc/BRIEF.md
# Node Cache Coherence Controller

This block is the cache-side agent of one node in a directory-coherent multiprocessor. It holds a small direct-mapped cache with one word per line. Each line carries a tag, a data word and a coherence state: Invalid, Shared (readable copy) or Exclusive (the only copy, writable and dirty). Processor loads and stores that find enough permission finish at once. All other accesses turn into messages to the home directory, and the processor stalls until the directory supplies the line.

Directory requests arrive on a separate input. Each one can invalidate a copy, fetch the data of an owned line, or do both, and each is answered one cycle later on the single outgoing message channel. An answer on that channel takes priority over any message the processor side wants to send. Replacing an owned line first sends its data home as a write-back, and only then sends the miss. No write to a line that is not Exclusive is done locally: every such write becomes a write miss.

Top module: `node_coh_ctrl`

## Requirements
- R1: After reset every line is Invalid and `cpu_stall`, `cpu_done` and `msg_out_valid` are low, so the first access to any address misses.
- R2: A load that misses sends a read-miss message (kind 0) carrying the full load address. When `fill_valid` returns the data, the load completes with that data in `cpu_rdata` and the line becomes Shared.
- R3: A store to a line that is Invalid, Shared or held under another tag sends a write-miss message (kind 1) with the store address. When the fill arrives, the line becomes Exclusive and holds the store data.
- R4: From the cycle a miss is accepted until its completion, `cpu_stall` is high. `cpu_done` is a one-cycle pulse and is never high while `cpu_stall` is high.
- R5: A load to a Shared or Exclusive line with a matching tag, or a store to an Exclusive line with a matching tag, raises `cpu_done` on the clock edge that samples the request, sends no message and never raises `cpu_stall`.
- R6: When a miss needs a line that is Exclusive under a different tag, a write-back (kind 2) carrying the victim's full address and data is sent before the miss message. A Shared victim is dropped with no message.
- R7: A fetch request (request kind 1) to an Exclusive line returns a data reply (kind 3) with the line's data, and the line becomes Shared.
- R8: An invalidate request (request kind 0) to a present line makes it Invalid and returns an acknowledge (kind 4).
- R9: A fetch-invalidate request (request kind 2) to an Exclusive line returns a data reply with the line's data. To a Shared line it returns an acknowledge. In both cases the line becomes Invalid.
- R10: Any directory request to a line that is Invalid, or that is held under a different tag, returns an acknowledge and leaves the cached line and its data unchanged.
- R11: Every directory request is answered on the next cycle with a data reply or an acknowledge carrying the request address. A processor request in the same cycle is held off, and its message follows afterwards.
- R12: A load hit returns the most recent value stored to that address by a store hit or by a completed write miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor access request, held until `cpu_done` |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Word address of the access |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_stall | output | 1 | Processor stalled on an outstanding miss |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load result, valid with `cpu_done` |
| msg_out_valid | output | 1 | Outgoing message present this cycle |
| msg_out_kind | output | 3 | 0 read miss, 1 write miss, 2 write-back, 3 data reply, 4 acknowledge |
| msg_out_addr | output | ADDR_W | Address carried by the message |
| msg_out_data | output | DATA_W | Data carried by write-back and data reply |
| fill_valid | input | 1 | Directory supplies the line for the outstanding miss |
| fill_data | input | DATA_W | Line data from the directory |
| dir_req_valid | input | 1 | Directory request present |
| dir_req_kind | input | 2 | 0 invalidate, 1 fetch, 2 fetch-invalidate |
| dir_req_addr | input | ADDR_W | Address the directory request targets |

## Verification
The bench builds the block with four lines, 6-bit addresses and 16-bit data. With only four indexes and three tags per index in the address pool, random traffic runs into conflict misses all the time. Exclusive victims therefore force write-backs often, and directory requests keep landing on present, absent and wrong-tag lines. A directed case raises a processor miss and a directory request in the same cycle, which exercises the priority of replies on the shared message channel.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2
  } line_st_e;

  typedef enum logic [2:0] {
    MO_RD_MISS = 3'd0,
    MO_WR_MISS = 3'd1,
    MO_WRBACK  = 3'd2,
    MO_DATA    = 3'd3,
    MO_ACK     = 3'd4
  } msg_kind_e;

  localparam logic [1:0] DK_INV       = 2'd0;
  localparam logic [1:0] DK_FETCH     = 2'd1;
  localparam logic [1:0] DK_FETCH_INV = 2'd2;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_SEND = 2'd1,
    FS_WAIT = 2'd2
  } fsm_st_e;
endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int NLINES = 16,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  c_idx,
  output line_st_e          c_st,
  output logic [TAG_W-1:0]  c_tag,
  output logic [DATA_W-1:0] c_data,
  input  logic [IDX_W-1:0]  d_idx,
  output line_st_e          d_st,
  output logic [TAG_W-1:0]  d_tag,
  output logic [DATA_W-1:0] d_data,
  input  logic              a_we_st,
  input  logic              a_we_td,
  input  logic [IDX_W-1:0]  a_idx,
  input  line_st_e          a_st,
  input  logic [TAG_W-1:0]  a_tag,
  input  logic [DATA_W-1:0] a_data,
  input  logic              b_we_st,
  input  logic [IDX_W-1:0]  b_idx,
  input  line_st_e          b_st
);
  line_st_e          st_q   [NLINES];
  logic [TAG_W-1:0]  tag_q  [NLINES];
  logic [DATA_W-1:0] data_q [NLINES];

  // State bits need reset and two writers; port A wins on the same index.
  for (genvar i = 0; i < NLINES; i++) begin : g_state
    always_ff @(posedge clk) begin
      if (rst)
        st_q[i] <= LS_INV;
      else if (a_we_st && a_idx == IDX_W'(i))
        st_q[i] <= a_st;
      else if (b_we_st && b_idx == IDX_W'(i))
        st_q[i] <= b_st;
    end
  end

  // Tag and data: one writer, no reset, so they map onto RAM.
  always_ff @(posedge clk) begin
    if (a_we_td) begin
      tag_q[a_idx]  <= a_tag;
      data_q[a_idx] <= a_data;
    end
  end

  assign c_st   = st_q[c_idx];
  assign c_tag  = tag_q[c_idx];
  assign c_data = data_q[c_idx];
  assign d_st   = st_q[d_idx];
  assign d_tag  = tag_q[d_idx];
  assign d_data = data_q[d_idx];
endmodule

// File: rtl/coh_dir_resp.sv
module coh_dir_resp
  import coh_pkg::*;
#(
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [TAG_W-1:0]  req_tag,
  input  line_st_e          d_st,
  input  logic [TAG_W-1:0]  d_tag,
  input  logic [DATA_W-1:0] d_data,
  output msg_kind_e         resp_kind,
  output logic [DATA_W-1:0] resp_data,
  output logic              st_we,
  output line_st_e          st_new
);
  logic present;
  logic st_chg;

  assign present = (d_st != LS_INV) && (d_tag == req_tag);

  always_comb begin
    resp_kind = MO_ACK;
    resp_data = '0;
    st_chg    = 1'b0;
    st_new    = d_st;
    case (req_kind)
      DK_INV: begin
        if (present) begin
          st_chg = 1'b1;
          st_new = LS_INV;
        end
      end
      DK_FETCH: begin
        if (present && d_st == LS_EXC) begin
          resp_kind = MO_DATA;
          resp_data = d_data;
          st_chg    = 1'b1;
          st_new    = LS_SHR;
        end
      end
      DK_FETCH_INV: begin
        if (present) begin
          st_chg = 1'b1;
          st_new = LS_INV;
          if (d_st == LS_EXC) begin
            resp_kind = MO_DATA;
            resp_data = d_data;
          end
        end
      end
      default: ;
    endcase
  end

  assign st_we = req_valid && st_chg;
endmodule

// File: rtl/coh_cpu_fsm.sv
module coh_cpu_fsm
  import coh_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              done_q,
  input  logic              chan_busy,
  output logic [IDX_W-1:0]  look_idx,
  input  line_st_e          look_st,
  input  logic [TAG_W-1:0]  look_tag,
  input  logic [DATA_W-1:0] look_data,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data,
  output logic              msg_want,
  output msg_kind_e         msg_kind,
  output logic [ADDR_W-1:0] msg_addr,
  output logic [DATA_W-1:0] msg_data,
  output logic              wr_st,
  output logic              wr_td,
  output line_st_e          wr_state,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [DATA_W-1:0] wr_data,
  output logic              done_set,
  output logic [DATA_W-1:0] rdata_val,
  output logic              stall_next
);
  fsm_st_e           cur, nxt;
  logic              lat_we;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_wdata;
  logic              lat_load;
  logic [ADDR_W-1:0] sel_addr;
  logic              tag_hit;
  logic              perm_ok;

  assign sel_addr = (cur == FS_IDLE) ? cpu_addr : lat_addr;
  assign look_idx = sel_addr[IDX_W-1:0];
  assign tag_hit  = (look_tag == sel_addr[ADDR_W-1:IDX_W]);
  assign perm_ok  = cpu_we ? (look_st == LS_EXC && tag_hit)
                           : (look_st != LS_INV && tag_hit);

  always_comb begin
    nxt       = cur;
    lat_load  = 1'b0;
    msg_want  = 1'b0;
    msg_kind  = MO_RD_MISS;
    msg_addr  = lat_addr;
    msg_data  = '0;
    wr_st     = 1'b0;
    wr_td     = 1'b0;
    wr_state  = LS_INV;
    wr_tag    = sel_addr[ADDR_W-1:IDX_W];
    wr_data   = cpu_wdata;
    done_set  = 1'b0;
    rdata_val = look_data;
    case (cur)
      FS_IDLE: begin
        if (cpu_valid && !done_q && !chan_busy) begin
          if (perm_ok) begin
            done_set = 1'b1;
            if (cpu_we) begin
              wr_st    = 1'b1;
              wr_td    = 1'b1;
              wr_state = LS_EXC;
            end
          end else begin
            lat_load = 1'b1;
            msg_want = 1'b1;
            if (look_st == LS_EXC && !tag_hit) begin
              msg_kind = MO_WRBACK;
              msg_addr = {look_tag, look_idx};
              msg_data = look_data;
              wr_st    = 1'b1;
              wr_state = LS_INV;
              nxt      = FS_SEND;
            end else begin
              msg_kind = cpu_we ? MO_WR_MISS : MO_RD_MISS;
              msg_addr = cpu_addr;
              nxt      = FS_WAIT;
            end
          end
        end
      end
      FS_SEND: begin
        if (!chan_busy) begin
          msg_want = 1'b1;
          msg_kind = lat_we ? MO_WR_MISS : MO_RD_MISS;
          nxt      = FS_WAIT;
        end
      end
      FS_WAIT: begin
        if (fill_valid) begin
          wr_st     = 1'b1;
          wr_td     = 1'b1;
          wr_state  = lat_we ? LS_EXC : LS_SHR;
          wr_data   = lat_we ? lat_wdata : fill_data;
          rdata_val = fill_data;
          done_set  = 1'b1;
          nxt       = FS_IDLE;
        end
      end
      default: nxt = FS_IDLE;
    endcase
  end

  assign stall_next = (nxt != FS_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur       <= FS_IDLE;
      lat_we    <= 1'b0;
      lat_addr  <= '0;
      lat_wdata <= '0;
    end else begin
      cur <= nxt;
      if (lat_load) begin
        lat_we    <= cpu_we;
        lat_addr  <= cpu_addr;
        lat_wdata <= cpu_wdata;
      end
    end
  end
endmodule

// File: rtl/node_coh_ctrl.sv
module node_coh_ctrl
  import coh_pkg::*;
#(
  parameter int NLINES = 16,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_stall,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              msg_out_valid,
  output logic [2:0]        msg_out_kind,
  output logic [ADDR_W-1:0] msg_out_addr,
  output logic [DATA_W-1:0] msg_out_data,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              dir_req_valid,
  input  logic [1:0]        dir_req_kind,
  input  logic [ADDR_W-1:0] dir_req_addr
);
  localparam int IDX_W = $clog2(NLINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  c_idx;
  line_st_e          c_st, d_st;
  logic [TAG_W-1:0]  c_tag, d_tag;
  logic [DATA_W-1:0] c_data, d_data;

  logic              f_msg_want;
  msg_kind_e         f_msg_kind;
  logic [ADDR_W-1:0] f_msg_addr;
  logic [DATA_W-1:0] f_msg_data;
  logic              f_wr_st, f_wr_td;
  line_st_e          f_wr_state;
  logic [TAG_W-1:0]  f_wr_tag;
  logic [DATA_W-1:0] f_wr_data;
  logic              f_done_set;
  logic [DATA_W-1:0] f_rdata;
  logic              f_stall_next;

  msg_kind_e         r_kind;
  logic [DATA_W-1:0] r_data;
  logic              r_st_we;
  line_st_e          r_st_new;

  coh_line_store #(
    .NLINES(NLINES), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_lines (
    .clk    (clk),
    .rst    (rst),
    .c_idx  (c_idx),
    .c_st   (c_st),
    .c_tag  (c_tag),
    .c_data (c_data),
    .d_idx  (dir_req_addr[IDX_W-1:0]),
    .d_st   (d_st),
    .d_tag  (d_tag),
    .d_data (d_data),
    .a_we_st(f_wr_st),
    .a_we_td(f_wr_td),
    .a_idx  (c_idx),
    .a_st   (f_wr_state),
    .a_tag  (f_wr_tag),
    .a_data (f_wr_data),
    .b_we_st(r_st_we),
    .b_idx  (dir_req_addr[IDX_W-1:0]),
    .b_st   (r_st_new)
  );

  coh_dir_resp #(
    .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_dir (
    .req_valid(dir_req_valid),
    .req_kind (dir_req_kind),
    .req_tag  (dir_req_addr[ADDR_W-1:IDX_W]),
    .d_st     (d_st),
    .d_tag    (d_tag),
    .d_data   (d_data),
    .resp_kind(r_kind),
    .resp_data(r_data),
    .st_we    (r_st_we),
    .st_new   (r_st_new)
  );

  coh_cpu_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .cpu_valid (cpu_req_valid),
    .cpu_we    (cpu_req_we),
    .cpu_addr  (cpu_req_addr),
    .cpu_wdata (cpu_req_wdata),
    .done_q    (cpu_done),
    .chan_busy (dir_req_valid),
    .look_idx  (c_idx),
    .look_st   (c_st),
    .look_tag  (c_tag),
    .look_data (c_data),
    .fill_valid(fill_valid),
    .fill_data (fill_data),
    .msg_want  (f_msg_want),
    .msg_kind  (f_msg_kind),
    .msg_addr  (f_msg_addr),
    .msg_data  (f_msg_data),
    .wr_st     (f_wr_st),
    .wr_td     (f_wr_td),
    .wr_state  (f_wr_state),
    .wr_tag    (f_wr_tag),
    .wr_data   (f_wr_data),
    .done_set  (f_done_set),
    .rdata_val (f_rdata),
    .stall_next(f_stall_next)
  );

  // Registered outputs; directory replies own the channel when present.
  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_stall     <= 1'b0;
      cpu_done      <= 1'b0;
      cpu_rdata     <= '0;
      msg_out_valid <= 1'b0;
      msg_out_kind  <= 3'd0;
      msg_out_addr  <= '0;
      msg_out_data  <= '0;
    end else begin
      cpu_stall     <= f_stall_next;
      cpu_done      <= f_done_set;
      if (f_done_set) cpu_rdata <= f_rdata;
      msg_out_valid <= dir_req_valid || f_msg_want;
      if (dir_req_valid) begin
        msg_out_kind <= r_kind;
        msg_out_addr <= dir_req_addr;
        msg_out_data <= r_data;
      end else begin
        msg_out_kind <= f_msg_kind;
        msg_out_addr <= f_msg_addr;
        msg_out_data <= f_msg_data;
      end
    end
  end
endmodule

// File: rtl/node_coh_ctrl_sva.sv
module node_coh_ctrl_sva (
  input logic       clk,
  input logic       rst,
  input logic       dir_req_valid,
  input logic       msg_out_valid,
  input logic [2:0] msg_out_kind,
  input logic       cpu_done,
  input logic       cpu_stall
);
  a_r4_done_no_stall: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> !cpu_stall);

  a_r4_done_pulse: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> !cpu_done);

  a_r11_dir_answered: assert property (@(posedge clk) disable iff (rst)
    dir_req_valid |=> (msg_out_valid && (msg_out_kind == 3'd3 || msg_out_kind == 3'd4)));

  a_r6_wb_followed: assert property (@(posedge clk) disable iff (rst)
    (msg_out_valid && msg_out_kind == 3'd2) |=> msg_out_valid);

  a_r3_miss_stalls: assert property (@(posedge clk) disable iff (rst)
    (msg_out_valid && msg_out_kind <= 3'd1) |-> cpu_stall);
endmodule

bind node_coh_ctrl node_coh_ctrl_sva u_sva (.*);

// File: tb/node_coh_ctrl_bench.sv
module node_coh_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 4;
  localparam int AW = 6;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          cpu_req_valid, cpu_req_we;
  logic [AW-1:0] cpu_req_addr;
  logic [DW-1:0] cpu_req_wdata;
  logic          cpu_stall, cpu_done;
  logic [DW-1:0] cpu_rdata;
  logic          msg_out_valid;
  logic [2:0]    msg_out_kind;
  logic [AW-1:0] msg_out_addr;
  logic [DW-1:0] msg_out_data;
  logic          fill_valid;
  logic [DW-1:0] fill_data;
  logic          dir_req_valid;
  logic [1:0]    dir_req_kind;
  logic [AW-1:0] dir_req_addr;

  node_coh_ctrl #(.NLINES(NL), .ADDR_W(AW), .DATA_W(DW)) u_node_coh_ctrl (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Reference model: state 0 Invalid, 1 Shared, 2 Exclusive
  int          m_st   [NL];
  logic [3:0]  m_tag  [NL];
  logic [DW-1:0] m_data [NL];
  logic [DW-1:0] mem  [64];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic bit present(input logic [AW-1:0] a);
    return m_st[a[1:0]] != 0 && m_tag[a[1:0]] == a[5:2];
  endfunction

  task automatic cpu_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd);
    int idx = int'(a[1:0]);
    bit hit = we ? (m_st[idx] == 2 && m_tag[idx] == a[5:2]) : present(a);
    bit wb  = !hit && m_st[idx] == 2 && m_tag[idx] != a[5:2];
    int nmsg = 0;
    int done_at = -1;
    bit stall_seen = 0;
    logic [2:0]    mk [4];
    logic [AW-1:0] ma [4];
    logic [DW-1:0] md [4];
    logic [DW-1:0] rd = '0;
    @(negedge clk);
    cpu_req_valid = 1; cpu_req_we = we; cpu_req_addr = a; cpu_req_wdata = wd;
    for (int c = 0; c < 40 && done_at < 0; c++) begin
      @(negedge clk);
      fill_valid = 0;
      if (cpu_stall) stall_seen = 1;
      if (msg_out_valid && nmsg < 4) begin
        mk[nmsg] = msg_out_kind; ma[nmsg] = msg_out_addr; md[nmsg] = msg_out_data;
        if (msg_out_kind <= 3'd1) begin
          fill_valid = 1;
          fill_data  = mem[msg_out_addr];
        end
        nmsg++;
      end
      if (cpu_done) begin
        done_at = c;
        rd = cpu_rdata;
        chk(!cpu_stall, "R4 done with stall", 1, 0);
      end
    end
    cpu_req_valid = 0;
    fill_valid = 0;
    chk(done_at >= 0, "R4 access never completed", done_at, 0);
    if (hit) begin
      chk(nmsg == 0, "R5 hit sent message", nmsg, 0);
      chk(done_at == 0, "R5 hit latency", done_at, 0);
      chk(!stall_seen, "R5 hit stalled", 1, 0);
      if (!we) chk(rd == m_data[idx], "R12 hit data", rd, m_data[idx]);
      if (we) m_data[idx] = wd;
    end else begin
      int mi = wb ? 1 : 0;
      chk(nmsg == mi + 1, "R6 message count", nmsg, mi + 1);
      chk(stall_seen, "R4 stall during miss", 0, 1);
      if (wb) begin
        chk(mk[0] == 3'd2, "R6 writeback kind", mk[0], 2);
        chk(ma[0] == {m_tag[idx], a[1:0]}, "R6 writeback addr", ma[0], {m_tag[idx], a[1:0]});
        chk(md[0] == m_data[idx], "R6 writeback data", md[0], m_data[idx]);
        mem[{m_tag[idx], a[1:0]}] = m_data[idx];
      end
      if (we) chk(mk[mi] == 3'd1, "R3 write miss kind", mk[mi], 1);
      else    chk(mk[mi] == 3'd0, "R2 read miss kind", mk[mi], 0);
      chk(ma[mi] == a, "R2 miss addr", ma[mi], a);
      if (!we) chk(rd == mem[a], "R2 fill data", rd, mem[a]);
      m_tag[idx]  = a[5:2];
      m_st[idx]   = we ? 2 : 1;
      m_data[idx] = we ? wd : mem[a];
    end
  endtask

  task automatic dir_op(input logic [1:0] k, input logic [AW-1:0] a);
    int idx = int'(a[1:0]);
    bit p = present(a);
    bit exc = p && m_st[idx] == 2;
    bit data_exp = exc && (k == 2'd1 || k == 2'd2);
    @(negedge clk);
    dir_req_valid = 1; dir_req_kind = k; dir_req_addr = a;
    @(negedge clk);
    dir_req_valid = 0;
    chk(msg_out_valid, "R11 reply missing", 0, 1);
    chk(msg_out_addr == a, "R11 reply addr", msg_out_addr, a);
    if (!p) chk(msg_out_kind == 3'd4, "R10 absent line ack", msg_out_kind, 4);
    else if (k == 2'd1) begin
      if (exc) chk(msg_out_kind == 3'd3, "R7 fetch data reply", msg_out_kind, 3);
      else     chk(msg_out_kind == 3'd4, "R7 fetch shared ack", msg_out_kind, 4);
    end else if (k == 2'd0) chk(msg_out_kind == 3'd4, "R8 invalidate ack", msg_out_kind, 4);
    else begin
      if (exc) chk(msg_out_kind == 3'd3, "R9 fetch-inv data", msg_out_kind, 3);
      else     chk(msg_out_kind == 3'd4, "R9 fetch-inv ack", msg_out_kind, 4);
    end
    if (data_exp) begin
      chk(msg_out_data == m_data[idx], "R7 reply data", msg_out_data, m_data[idx]);
      mem[a] = m_data[idx];
    end
    if (p) begin
      if (k == 2'd0 || k == 2'd2) m_st[idx] = 0;
      else if (k == 2'd1 && exc) m_st[idx] = 1;
    end
  endtask

  function automatic logic [AW-1:0] pick_addr();
    logic [3:0] t = 4'($urandom % 3);
    logic [1:0] i = 2'($urandom % 4);
    return {t, i};
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired act=0 exp=1");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NL; i++) begin m_st[i] = 0; m_tag[i] = '0; m_data[i] = '0; end
    for (int i = 0; i < 64; i++) mem[i] = 16'(i * 37 + 5);
    rst = 1; cpu_req_valid = 0; cpu_req_we = 0; cpu_req_addr = '0; cpu_req_wdata = '0;
    fill_valid = 0; fill_data = '0; dir_req_valid = 0; dir_req_kind = '0; dir_req_addr = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!msg_out_valid, "R1 reset msg", msg_out_valid, 0);
    chk(!cpu_stall, "R1 reset stall", cpu_stall, 0);
    chk(!cpu_done, "R1 reset done", cpu_done, 0);

    // R11: processor miss and directory request in the same cycle
    cpu_req_valid = 1; cpu_req_we = 0; cpu_req_addr = 6'h05; cpu_req_wdata = '0;
    dir_req_valid = 1; dir_req_kind = 2'd1; dir_req_addr = 6'h22;
    @(negedge clk);
    dir_req_valid = 0;
    chk(msg_out_valid && msg_out_kind == 3'd4, "R11 reply first", msg_out_kind, 4);
    chk(!cpu_stall, "R11 cpu held off", cpu_stall, 0);
    @(negedge clk);
    chk(msg_out_valid && msg_out_kind == 3'd0, "R1 first access misses", msg_out_kind, 0);
    chk(msg_out_addr == 6'h05, "R11 delayed miss addr", msg_out_addr, 6'h05);
    fill_valid = 1; fill_data = mem[6'h05];
    @(negedge clk);
    fill_valid = 0;
    chk(cpu_done && cpu_rdata == mem[6'h05], "R2 fill result", cpu_rdata, mem[6'h05]);
    cpu_req_valid = 0;
    m_st[1] = 1; m_tag[1] = 4'h1; m_data[1] = mem[6'h05];

    // Directed corners
    cpu_op(1, 6'h05, 16'hA5A5);   // R3 upgrade of Shared line
    cpu_op(0, 6'h05, '0);         // R12 hit sees store
    cpu_op(1, 6'h05, 16'h1234);   // R5 store hit
    dir_op(2'd1, 6'h09);          // R10 wrong tag ack, line kept
    cpu_op(0, 6'h05, '0);         // R10 line still valid with data
    dir_op(2'd1, 6'h05);          // R7 fetch Exclusive
    cpu_op(1, 6'h05, 16'h7777);   // R3 write on Shared
    cpu_op(0, 6'h09, '0);         // R6 write-back of Exclusive victim
    cpu_op(0, 6'h05, '0);         // R6 Shared victim silent
    dir_op(2'd0, 6'h05);          // R8 invalidate
    cpu_op(1, 6'h0A, 16'hBEEF);
    dir_op(2'd2, 6'h0A);          // R9 fetch-invalidate Exclusive
    cpu_op(0, 6'h0A, '0);         // R9 line refetched
    dir_op(2'd2, 6'h0A);          // R9 fetch-invalidate Shared

    for (int n = 0; n < 400; n++) begin
      if ($urandom % 8 < 5) cpu_op(1'($urandom % 2), pick_addr(), 16'($urandom));
      else dir_op(2'($urandom % 3), pick_addr());
    end
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule